// File: doc/BRIEF.md
# PDM-to-PCM CIC Decimator

This block turns the one-bit pulse-density stream of a single microphone channel into signed 24-bit PCM samples. Each bit accepted from the capture stage is mapped to +1 or -1 and passed through a third-order cascaded integrator-comb filter. The filter is decimated by a ratio chosen with a 3-bit code. After every ratio-many accepted bits, the block emits one scaled and saturated sample together with a single-cycle valid strobe.

One instance serves one channel. A multi-channel front end places several instances side by side, each fed by its own capture strobe. The ratio code selects 32, 64, 128 or 256, or the non-binary ratio 100. For each ratio a fixed power-of-two gain is applied, chosen so that a full-scale input lands at or just below the 24-bit full scale. Dropping the enable or changing the ratio code returns the filter to a clean start.

Top module: `pdm_cic_decim`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pcm_valid` is 0 and `pcm_data` is 0.
- R2: Bits count only when `bit_valid` is high. `ratio_code` 000 selects 32, 001 selects 64, 010 selects 128, 011 selects 256 and 100 selects 100; codes 101, 110 and 111 behave as 000. Exactly one strobe is produced per R accepted bits, on the R-th, 2R-th and later bits. `bit_in` is ignored when `bit_valid` is low.
- R3: `pcm_valid` rises in the clock cycle right after the edge that accepts the R-th bit, and stays high for exactly one cycle.
- R4: Bit 1 counts as +1 and bit 0 as -1. The filter response to a constant input is R^3 times that value, scaled by 2^s and saturated to the signed 24-bit range. The shift s is +8 for R=32, +5 for R=64, +2 for R=128, -1 for R=256 (arithmetic right shift) and +3 for R=100. A steady all-ones stream therefore gives 8388607 for powers of two and 8000000 for R=100. A steady all-zeros stream gives -8388608 and -8000000.
- R5: A steady alternating 1,0 stream settles to 0. A repeating 1,1,1,0 stream settles to half of the full-scale value (R^3/2, scaled as in R4).
- R6: `pcm_data` changes only on cycles where `pcm_valid` is high.
- R7: While `enable` is low, no strobe is produced and the integrators, combs and bit counter are cleared. After re-enable, the first strobe comes after R accepted bits. For an all-ones input it carries (R+2)(R+1)R/6 scaled as in R4.
- R8: A change of `ratio_code` clears the same state as R7. The first strobe under the new ratio comes after R new bits and carries the fresh-start value of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel enable; low clears the filter |
| ratio_code | input | 3 | Decimation ratio select |
| bit_valid | input | 1 | Strobe marking a captured PDM bit |
| bit_in | input | 1 | Captured PDM bit |
| pcm_valid | output | 1 | One-cycle strobe for a new sample |
| pcm_data | output | 24 | Signed PCM sample, held between strobes |

## Verification
The assertions check the following on every cycle:
- the strobe is a single-cycle pulse that follows an accepted bit;
- the sample stays unchanged between strobes;
- no strobe appears the cycle after a disable or a ratio-code change;
- the bit counter wraps to zero on the last bit of each decimation window.

Only the bench scenarios can show that the strobe spacing matches each ratio code, including the reserved codes. The same holds for the numeric results: the settled outputs for constant, alternating and three-quarter-density streams, which are compared with closed-form values of R^3, and the fresh-start value after a disable or a ratio switch.

// File: rtl/pdm_cic_pkg.sv
package pdm_cic_pkg;

    localparam int CIC_ORDER = 3;
    localparam int OUT_W     = 24;
    localparam int ACC_W     = 1 + CIC_ORDER * 8 + 3;
    localparam int CNT_W     = 8;
    localparam int SH_W      = 5;

    typedef logic signed [ACC_W-1:0] acc_t;
    typedef logic signed [OUT_W-1:0] pcm_t;

    typedef enum logic [2:0] {
        DEC_32  = 3'b000,
        DEC_64  = 3'b001,
        DEC_128 = 3'b010,
        DEC_256 = 3'b011,
        DEC_100 = 3'b100
    } dec_code_e;

    typedef struct packed {
        logic [CNT_W-1:0]        last;
        logic signed [SH_W-1:0]  shift;
    } dec_cfg_t;

    function automatic dec_cfg_t decode_ratio(input logic [2:0] code);
        dec_cfg_t cfg;
        case (code)
            DEC_64:  begin cfg.last = CNT_W'(63);  cfg.shift = SH_W'(5);  end
            DEC_128: begin cfg.last = CNT_W'(127); cfg.shift = SH_W'(2);  end
            DEC_256: begin cfg.last = CNT_W'(255); cfg.shift = -SH_W'(1); end
            DEC_100: begin cfg.last = CNT_W'(99);  cfg.shift = SH_W'(3);  end
            default: begin cfg.last = CNT_W'(31);  cfg.shift = SH_W'(8);  end
        endcase
        return cfg;
    endfunction

endpackage

// File: rtl/cic_decim_counter.sv
module cic_decim_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] last,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap = tick && (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr)      cnt_q <= '0;
        else if (wrap)       cnt_q <= '0;
        else if (tick)       cnt_q <= cnt_q + 1'b1;
    end

    // R2: the window restarts right after its last bit
    a_r2_wrap_restart: assert property (@(posedge clk) disable iff (rst)
        (!clr && tick && cnt_q == last) |=> (cnt_q == '0));
endmodule

// File: rtl/cic_integ_chain.sv
module cic_integ_chain #(
    parameter int ORDER = 3,
    parameter int W     = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] x_in,
    output logic [W-1:0] sum_out
);
    logic [ORDER:0][W-1:0] link;

    assign link[0] = x_in;

    for (genvar i = 0; i < ORDER; i++) begin : g_stage
        logic [W-1:0] acc_q;
        assign link[i+1] = acc_q + link[i];
        always_ff @(posedge clk) begin
            if (rst || clr)  acc_q <= '0;
            else if (en)     acc_q <= link[i+1];
        end
    end

    assign sum_out = link[ORDER];
endmodule

// File: rtl/cic_comb_chain.sv
module cic_comb_chain #(
    parameter int ORDER = 3,
    parameter int W     = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [ORDER:0][W-1:0] link;

    assign link[0] = din;

    for (genvar i = 0; i < ORDER; i++) begin : g_stage
        logic [W-1:0] dly_q;
        assign link[i+1] = link[i] - dly_q;
        always_ff @(posedge clk) begin
            if (rst || clr)  dly_q <= '0;
            else if (en)     dly_q <= link[i];
        end
    end

    assign dout = link[ORDER];
endmodule

// File: rtl/pcm_scaler.sv
module pcm_scaler
    import pdm_cic_pkg::*;
(
    input  acc_t                   din,
    input  logic signed [SH_W-1:0] shift,
    output pcm_t                   dout
);
    localparam int WIDE_W = ACC_W + 16;
    localparam logic signed [WIDE_W-1:0] POS_MAX = WIDE_W'((64'sd1 <<< (OUT_W - 1)) - 1);
    localparam logic signed [WIDE_W-1:0] NEG_MIN = -WIDE_W'(64'sd1 <<< (OUT_W - 1));

    logic signed [WIDE_W-1:0] ext;
    logic signed [WIDE_W-1:0] wide;
    logic [SH_W-1:0]          amt;

    always_comb begin
        ext = WIDE_W'(din);
        amt = shift[SH_W-1] ? SH_W'(-shift) : SH_W'(shift);
        wide = shift[SH_W-1] ? (ext >>> amt) : (ext <<< amt);
        if (wide > POS_MAX)      dout = pcm_t'(POS_MAX);
        else if (wide < NEG_MIN) dout = pcm_t'(NEG_MIN);
        else                     dout = pcm_t'(wide);
    end
endmodule

// File: rtl/pdm_cic_decim.sv
module pdm_cic_decim
    import pdm_cic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic [2:0]  ratio_code,
    input  logic        bit_valid,
    input  logic        bit_in,
    output logic        pcm_valid,
    output logic [23:0] pcm_data
);
    dec_cfg_t   cfg;
    logic [2:0] code_q;
    logic       clr;
    logic       tick;
    logic       wrap;
    acc_t       x_val;
    logic [ACC_W-1:0] integ_out;
    logic [ACC_W-1:0] comb_out;
    pcm_t       scaled;

    assign cfg   = decode_ratio(ratio_code);
    assign clr   = !enable || (ratio_code != code_q);
    assign tick  = bit_valid && !clr;
    assign x_val = bit_in ? acc_t'(1) : -acc_t'(1);

    always_ff @(posedge clk) code_q <= ratio_code;

    cic_decim_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr), .tick(tick),
        .last(cfg.last), .wrap(wrap)
    );

    cic_integ_chain #(.ORDER(CIC_ORDER), .W(ACC_W)) u_integ (
        .clk(clk), .rst(rst), .clr(clr), .en(tick),
        .x_in(x_val), .sum_out(integ_out)
    );

    cic_comb_chain #(.ORDER(CIC_ORDER), .W(ACC_W)) u_comb (
        .clk(clk), .rst(rst), .clr(clr), .en(wrap),
        .din(integ_out), .dout(comb_out)
    );

    pcm_scaler u_scale (
        .din(acc_t'(comb_out)), .shift(cfg.shift), .dout(scaled)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pcm_valid <= 1'b0;
            pcm_data  <= '0;
        end else begin
            pcm_valid <= wrap;
            if (wrap) pcm_data <= scaled;
        end
    end

    // R3: strobe lasts one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |=> !pcm_valid);
    // R3: strobe follows an accepted bit
    a_r3_after_bit: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> $past(bit_valid && enable));
    // R6: sample held between strobes
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !pcm_valid |-> $stable(pcm_data));
    // R7: no strobe after a disabled cycle
    a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !pcm_valid);
    // R8: no strobe right after a ratio switch
    a_r8_switch: assert property (@(posedge clk) disable iff (rst)
        (ratio_code != code_q) |=> !pcm_valid);
endmodule

// File: tb/pdm_cic_decim_tb_top.sv
module pdm_cic_decim_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [2:0]  ratio_code = 3'b000;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        pcm_valid;
    logic [23:0] pcm_data;

    int errs = 0;
    int checks = 0;
    logic signed [23:0] held = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdm_cic_decim dut_i (
        .clk(clk), .rst(rst), .enable(enable), .ratio_code(ratio_code),
        .bit_valid(bit_valid), .bit_in(bit_in),
        .pcm_valid(pcm_valid), .pcm_data(pcm_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ratio_of(input int code);
        case (code)
            1: return 64;
            2: return 128;
            3: return 256;
            4: return 100;
            default: return 32;
        endcase
    endfunction

    function automatic longint scale(input longint raw, input int r);
        longint v;
        case (r)
            64:  v = raw * 32;
            128: v = raw * 4;
            256: v = raw >>> 1;
            100: v = raw * 8;
            default: v = raw * 256;
        endcase
        if (v > 8388607)  v = 8388607;
        if (v < -8388608) v = -8388608;
        return v;
    endfunction

    function automatic logic pat(input int kind, input int n);
        case (kind)
            0: return 1'b1;
            1: return 1'b0;
            2: return (n % 2) == 0;
            default: return (n % 4) != 3;
        endcase
    endfunction

    function automatic longint steady(input int kind, input int r);
        longint cube = longint'(r) * r * r;
        case (kind)
            0: return scale(cube, r);
            1: return scale(-cube, r);
            2: return 0;
            default: return scale(cube / 2, r);
        endcase
    endfunction

    function automatic longint fresh(input int r);
        return scale(longint'(r + 2) * (r + 1) * r / 6, r);
    endfunction

    // one bit with a strobe, then an idle cycle carrying a flipped bit_in
    task automatic send_bit(input logic b, output logic got_v, output logic signed [23:0] got_d);
        @(negedge clk); bit_valid = 1'b1; bit_in = b;
        @(negedge clk); bit_valid = 1'b0; bit_in = ~b;
        got_v = pcm_valid; got_d = pcm_data;
        if (!got_v) chk(got_d == held, "R6", got_d, held);
        held = got_d;
        @(negedge clk);
        chk(pcm_valid == 1'b0, "R3", pcm_valid, 0);
    endtask

    task automatic run_stream(input int code, input int kind, input int nout);
        int r = ratio_of(code);
        int k = 0;
        logic v;
        logic signed [23:0] d;
        @(negedge clk); enable = 1'b0; ratio_code = 3'(code);
        @(negedge clk); enable = 1'b1;
        @(negedge clk);
        for (int n = 0; n < r * nout; n++) begin
            send_bit(pat(kind, n), v, d);
            chk(v == (((n + 1) % r) == 0), "R2", v, ((n + 1) % r) == 0);
            if (v) begin
                k++;
                if (k == 1 && kind == 0) chk(d == fresh(r), "R7", d, fresh(r));
                if (k >= 4) chk(d == steady(kind, r), kind < 2 ? "R4" : "R5", d, steady(kind, r));
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic v;
        logic signed [23:0] d;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(pcm_valid == 1'b0 && pcm_data == '0, "R1", pcm_data, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(pcm_valid == 1'b0 && pcm_data == '0, "R1", pcm_data, 0);

        // R2 R4 R5: every valid code against four patterns
        for (int c = 0; c < 5; c++)
            for (int kind = 0; kind < 4; kind++)
                run_stream(c, kind, 5);
        // R2: reserved codes act as ratio 32
        for (int c = 5; c < 8; c++) run_stream(c, 0, 5);

        // R7: disable mid-window, feed ignored bits, re-enable
        run_stream(0, 1, 0);
        for (int n = 0; n < 16; n++) send_bit(1'b0, v, d);
        @(negedge clk); enable = 1'b0;
        for (int n = 0; n < 40; n++) begin
            send_bit(1'b1, v, d);
            chk(v == 1'b0, "R7", v, 0);
        end
        @(negedge clk); enable = 1'b1;
        for (int n = 0; n < 32; n++) begin
            send_bit(1'b1, v, d);
            chk(v == (n == 31), "R7", v, n == 31);
            if (v) chk(d == fresh(32), "R7", d, fresh(32));
        end

        // R8: switch ratio mid-window without disabling
        run_stream(0, 1, 0);
        for (int n = 0; n < 20; n++) send_bit(1'b0, v, d);
        @(negedge clk); ratio_code = 3'b001;
        for (int n = 0; n < 64; n++) begin
            send_bit(1'b1, v, d);
            chk(v == (n == 63), "R8", v, n == 63);
            if (v) chk(d == fresh(64), "R8", d, fresh(64));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule